// File: doc/BRIEF.md
# Serial-Programmed Glitch-Free Clock Freeze Controller

This block lets a two-wire serial link stop or release each of twelve clock outputs on its own. The link has a data line and a serial clock, and the data line is sampled on every rising serial clock edge. The receiver waits for a zero start bit and then collects a 12-bit enable word. It applies the whole word to a committed enable register on the edge that follows the last data bit. A one-cycle commit strobe marks that edge, and the committed word is visible on a status output.

Each of the twelve gated outputs has its own source clock and its own gate. A gate brings its enable bit into the source clock domain through a two-stage synchronizer. It captures the bit while the source clock is low and ANDs it with the source clock. As a result, an output only stops at a natural falling edge and only starts again at a natural rising edge, so every pulse it emits has full width. Two further clocks have no enable bit and pass straight through.

Top module: `frz_ctrl`

## Requirements
- R1: During and after synchronous reset (`rst` high), `en_status` reads 12'hFFF, `commit` is 0, the receiver is idle, and every gated output follows its source clock.
- R2: While idle, data samples of 1 are ignored: `en_status` does not change and `commit` stays 0.
- R3: A frame is a 0 start bit followed by 12 data bits. The k-th data bit after the start bit (k = 0..11) lands in `en_status[k]` and controls `gclk_out[k]`.
- R4: `en_status` holds its old value while data bits are being shifted in. The new word is applied on the rising serial clock edge after the 12th data bit, and `commit` is high for exactly the one serial clock cycle that follows that edge.
- R5: If the bit sampled on the commit edge is 0, it serves as the start bit of the next frame, so frames can run back to back.
- R6: If the bit sampled on the commit edge is 1, the receiver idles until it samples a 0.
- R7: An enable bit of 0 holds its gated output at logic 0. An enable bit of 1 makes the output follow its source clock.
- R8: When an output enters freeze, it falls only at a natural falling edge of its source clock, so no high pulse is shortened.
- R9: When an output leaves freeze, it rises only at a natural rising edge of its source clock, so its first pulse has full width.
- R10: `free_out` equals `free_in` at all times, whatever the enable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, applied in every clock domain |
| frz_sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| frz_sdata | input | 1 | Serial data line carrying the start bit and the enable bits |
| src_clk | input | 12 | Source clocks for the gated outputs |
| free_in | input | 2 | Clocks that are never gated |
| gclk_out | output | 12 | Gated clock outputs |
| free_out | output | 2 | Pass-through copies of `free_in` |
| en_status | output | 12 | Committed enable word |
| commit | output | 1 | One serial-clock-cycle strobe when a frame is applied |

## Verification
A receiver whose bit counter or state is wrong shows up on the serial clock edge where the frame should commit. The strobe either appears at the wrong edge or does not appear, and the scoreboard sees it at once. A wrong bit order or a wrong back-to-back frame shows up as a wrong `en_status` word at that same commit. A gate that samples its enable at the wrong phase shows up on the gated output as a high pulse narrower than half the source period. The bench measures every gated pulse, so such a fault is caught on the first freeze or release after the word reaches that domain. Outputs that are frozen or running when they should not be are caught within a few source cycles of each commit.

// File: rtl/frz_pkg.sv
package frz_pkg;

    localparam int GATED_N  = 12;
    localparam int FREE_N   = 2;
    localparam int SYNC_LEN = 2;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_DATA = 2'd1,
        RX_LOAD = 2'd2
    } rx_state_t;

    function automatic logic is_last(input int unsigned idx, input int unsigned width);
        return idx == width - 1;
    endfunction

endpackage

// File: rtl/frz_serial_rx.sv
module frz_serial_rx
    import frz_pkg::*;
#(
    parameter int WIDTH = GATED_N
) (
    input  logic             sclk,
    input  logic             rst,
    input  logic             sdata,
    output logic [WIDTH-1:0] en_word,
    output logic             commit
);
    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    rx_state_t        state;
    logic [CNT_W-1:0] bit_cnt;
    logic [WIDTH-1:0] shreg;

    always_ff @(posedge sclk) begin
        if (rst) begin
            state   <= RX_IDLE;
            bit_cnt <= '0;
            shreg   <= '1;
            en_word <= '1;
            commit  <= 1'b0;
        end else begin
            commit <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (!sdata) begin
                        state   <= RX_DATA;
                        bit_cnt <= '0;
                    end
                end
                RX_DATA: begin
                    shreg <= {sdata, shreg[WIDTH-1:1]};
                    if (is_last(32'(bit_cnt), WIDTH)) begin
                        state <= RX_LOAD;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                RX_LOAD: begin
                    en_word <= shreg;
                    commit  <= 1'b1;
                    bit_cnt <= '0;
                    state   <= sdata ? RX_IDLE : RX_DATA;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R4
    en_hold_chk: assert property (@(posedge sclk) disable iff (rst)
        (en_word != $past(en_word)) |-> commit);

    // R4
    commit_single_chk: assert property (@(posedge sclk) disable iff (rst)
        commit |=> !commit);

    // R3
    bit_cnt_range_chk: assert property (@(posedge sclk) disable iff (rst)
        32'(bit_cnt) < WIDTH);

    // R2
    idle_quiet_chk: assert property (@(posedge sclk) disable iff (rst)
        (state == RX_IDLE) |=> (en_word == $past(en_word)));

endmodule

// File: rtl/frz_gate.sv
module frz_gate
    import frz_pkg::*;
#(
    parameter int STAGES = SYNC_LEN
) (
    input  logic src_clk,
    input  logic rst,
    input  logic en_async,
    output logic gclk
);
    logic [STAGES-1:0] sync_q;
    logic              en_q;

    always_ff @(posedge src_clk) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], en_async};
        end
    end

    // capture while the source clock is low so the AND never cuts a pulse
    always_ff @(negedge src_clk) begin
        if (rst) begin
            en_q <= 1'b1;
        end else begin
            en_q <= sync_q[STAGES-1];
        end
    end

    assign gclk = src_clk & en_q;

    // R8 R9
    always @(en_q) begin
        if (rst === 1'b0) begin
            gate_edge_chk: assert (src_clk !== 1'b1);
        end
    end

endmodule

// File: rtl/frz_ctrl.sv
module frz_ctrl
    import frz_pkg::*;
#(
    parameter int N_GATED = GATED_N,
    parameter int N_FREE  = FREE_N,
    parameter int N_SYNC  = SYNC_LEN
) (
    input  logic               rst,
    input  logic               frz_sclk,
    input  logic               frz_sdata,
    input  logic [N_GATED-1:0] src_clk,
    input  logic [N_FREE-1:0]  free_in,
    output logic [N_GATED-1:0] gclk_out,
    output logic [N_FREE-1:0]  free_out,
    output logic [N_GATED-1:0] en_status,
    output logic               commit
);
    logic [N_GATED-1:0] en_word;

    frz_serial_rx #(.WIDTH(N_GATED)) u_rx (
        .sclk    (frz_sclk),
        .rst     (rst),
        .sdata   (frz_sdata),
        .en_word (en_word),
        .commit  (commit)
    );

    assign en_status = en_word;

    for (genvar g = 0; g < N_GATED; g++) begin : g_gate
        frz_gate #(.STAGES(N_SYNC)) u_gate (
            .src_clk  (src_clk[g]),
            .rst      (rst),
            .en_async (en_word[g]),
            .gclk     (gclk_out[g])
        );
    end

    assign free_out = free_in;

    // R10
    always_comb begin
        free_pass_chk: assert (free_out === free_in);
    end

endmodule

// File: tb/test_frz_ctrl.sv
`timescale 1ns/1ps
module test_frz_ctrl;
    localparam int  NG = 12;
    localparam int  NF = 2;
    localparam time SCLK_PERIOD = 20;
    localparam int  HALF_BASE = 3;

    logic          rst = 1'b1;
    logic          sclk = 1'b0;
    logic          sdata = 1'b1;
    logic [NG-1:0] src;
    logic [NF-1:0] free_in;
    logic [NG-1:0] gclk;
    logic [NF-1:0] free_out;
    logic [NG-1:0] en_status;
    logic          commit;

    int unsigned vectors = 0;
    int unsigned miscompares = 0;
    bit          run_ok = 1'b0;
    logic [NG-1:0] cur_en = '1;
    logic [NG-1:0] exp_q[$];

    frz_ctrl i_frz_ctrl (
        .rst(rst), .frz_sclk(sclk), .frz_sdata(sdata), .src_clk(src),
        .free_in(free_in), .gclk_out(gclk), .free_out(free_out),
        .en_status(en_status), .commit(commit)
    );

    always #(SCLK_PERIOD/2) sclk = ~sclk;

    for (genvar g = 0; g < NG; g++) begin : g_src
        localparam int H = HALF_BASE + g;
        realtime t_rise = -1.0;
        initial begin
            src[g] = 1'b0;
            forever #(H) src[g] = ~src[g];
        end
        always @(posedge gclk[g]) if (run_ok) t_rise = $realtime;
        // R8 R9: every gated high pulse is exactly half the source period
        always @(negedge gclk[g]) begin
            if (run_ok && t_rise >= 0.0) begin
                vectors++;
                if ($realtime - t_rise != real'(H)) begin
                    miscompares++;
                    $display("FAIL R8/R9 out %0d pulse width %0t expected %0d", g,
                             $realtime - t_rise, H);
                end
            end
        end
    end

    initial begin
        free_in = '0;
        fork
            forever #5 free_in[0] = ~free_in[0];
            forever #7 free_in[1] = ~free_in[1];
        join_none
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pop expected words on each commit strobe (R4)
    always @(negedge sclk) begin
        if (!rst && commit === 1'b1) begin
            vectors++;
            if (exp_q.size() == 0) begin
                miscompares++;
                $display("FAIL R2/R6 actual commit %h expected no commit", en_status);
            end else begin
                logic [NG-1:0] e;
                e = exp_q.pop_front();
                cur_en = e;
                if (en_status !== e) begin
                    miscompares++;
                    $display("FAIL R3/R4 actual %h expected %h", en_status, e);
                end
            end
        end
    end

    task automatic send_bit(input logic b, input bit chk_hold);
        @(negedge sclk);
        sdata = b;
        #(SCLK_PERIOD/4);
        if (chk_hold) check("R4 hold", 32'(en_status), 32'(cur_en));
    endtask

    // driver: a start bit then bit0 first; push the expected word
    task automatic send_frame(input logic [NG-1:0] w);
        exp_q.push_back(w);
        send_bit(1'b0, 1'b0);
        for (int k = 0; k < NG; k++) send_bit(w[k], 1'b1);
    endtask

    task automatic idle_bits(input int n);
        for (int k = 0; k < n; k++) send_bit(1'b1, 1'b0);
    endtask

    // R7: sample every output across a full slow period
    task automatic check_gates(input logic [NG-1:0] w, input string req);
        #400;
        #0.25;
        for (int s = 0; s < 2 * (HALF_BASE + NG); s++) begin
            for (int k = 0; k < NG; k++) begin
                vectors++;
                if (gclk[k] !== (src[k] & w[k])) begin
                    miscompares++;
                    $display("FAIL %s out %0d actual %b expected %b", req, k, gclk[k],
                             src[k] & w[k]);
                end
            end
            check("R10", 32'(free_out), 32'(free_in));
            #1;
        end
    endtask

    initial begin
        repeat (10) @(posedge sclk);
        #1;
        check("R1 status", 32'(en_status), 32'hFFF);
        check("R1 commit", 32'(commit), 32'h0);
        @(negedge sclk);
        rst = 1'b0;
        #1;
        run_ok = 1'b1;
        check_gates(12'hFFF, "R1 gates");

        // R2: long run of ones must not start a frame
        idle_bits(30);
        check("R2 status", 32'(en_status), 32'hFFF);

        // R3 R7: distinct bit pattern
        send_frame(12'h5C3);
        idle_bits(3);
        check("R3 status", 32'(en_status), 32'h5C3);
        check_gates(12'h5C3, "R7 pattern");

        // R5: back-to-back frames, start bit on the commit edge
        send_frame(12'h0F0);
        send_frame(12'hA69);
        idle_bits(2);
        check("R5 status", 32'(en_status), 32'hA69);
        check_gates(12'hA69, "R5 gates");

        // R6: a one on the commit edge, then idle, then a new frame
        send_frame(12'h000);
        idle_bits(7);
        check("R6 status", 32'(en_status), 32'h000);
        check_gates(12'h000, "R7 frozen");
        send_frame(12'hFFF);
        idle_bits(2);
        check_gates(12'hFFF, "R9 release");
        send_frame(12'h801);
        idle_bits(2);
        check("R3 edge bits", 32'(en_status), 32'h801);
        check_gates(12'h801, "R8 freeze");

        check("scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(SCLK_PERIOD * 20000);
        miscompares++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule